// File: doc/BRIEF.md
# CSR Read-Modify-Write Execution Unit

This unit executes the three atomic control-register instructions of a processor pipeline: swap, set-bits and clear-bits. For each request it takes a 12-bit register address, the operation code, the source operand, a flag that tells whether the instruction's source register field is nonzero, and the hart's current privilege level. It decides legality from the address bits alone. A legal request reads the register through a synchronous read port. The unit then returns the value it read and, when the operation calls for it, writes the merged value back through the write port. An illegal request touches neither port and is answered with an illegal-instruction flag.

The register file itself is outside the unit. It is reached through a plain port: a read strobe with an address, read data returned a fixed number of cycles later (`RD_LAT`), and a write strobe with data that shares the same address. The unit runs one legal operation at a time. While one is in flight it raises `busy` and drops any new request. A later read therefore always sees the earlier write.

Top module: `csr_rmw_unit`

## Requirements
- R1: The least privilege allowed to touch a register is its address bits [9:8], with user=0, supervisor=1, machine=3. A request whose `cur_priv` is numerically below that value is illegal.
- R2: Address bits [11:10] equal to 2'b11 mark a read-only register. A request on it that counts as a write is illegal, and one that does not count as a write is legal.
- R3: Swap (`req_op`=2'b01) always counts as a write, even when `req_src_nz` is 0. When legal it writes `req_src`.
- R4: Set and clear with `req_src_nz`=0 count as reads only. They return the old value and raise no write strobe, whatever `req_src` holds.
- R5: Set (`req_op`=2'b10) writes old OR `req_src`, and clear (`req_op`=2'b11) writes old AND NOT `req_src`. The code 2'b00 is reserved and always illegal.
- R6: A legal request accepted at a clock edge raises `csr_rd_en` for exactly one cycle, starting in the next cycle, with `csr_addr` holding the request address. `csr_rd_data` is taken `RD_LAT` cycles after the strobe. In the following cycle `rsp_valid` rises with `rsp_data` equal to the value read, and any write strobe rises in that same cycle.
- R7: An illegal request raises `rsp_valid` and `rsp_illegal` for one cycle, in the cycle after it is accepted. It raises neither `csr_rd_en` nor `csr_wr_en`.
- R8: `busy` is high from the cycle after a legal request is accepted until the cycle before its response. A request presented while `busy` is high is dropped: no strobe, no response, no register change. A request presented in the response cycle is accepted and reads the value just written.
- R9: After reset, `busy`, `csr_rd_en`, `csr_wr_en`, `rsp_valid` and `rsp_illegal` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 12 | Target register address |
| req_op | input | 2 | 01 swap, 10 set-bits, 11 clear-bits, 00 reserved |
| req_src | input | XLEN | Source operand |
| req_src_nz | input | 1 | Source register field of the instruction is nonzero |
| cur_priv | input | 2 | Current privilege level (0 user, 1 supervisor, 3 machine) |
| busy | output | 1 | A legal operation is in flight; requests are dropped |
| csr_rd_en | output | 1 | Read strobe to the register file |
| csr_addr | output | 12 | Address for both read and write |
| csr_rd_data | input | XLEN | Read data, valid RD_LAT cycles after the strobe |
| csr_wr_en | output | 1 | Write strobe to the register file |
| csr_wr_data | output | XLEN | Merged value to write |
| rsp_valid | output | 1 | Response present |
| rsp_illegal | output | 1 | Response is an illegal-instruction trap |
| rsp_data | output | XLEN | Register value read before any write |

## Verification
The bench builds the unit with `XLEN`=32 and `RD_LAT`=2. The two-cycle read latency stretches the busy window over several cycles, so a request dropped in the middle of an operation can be told apart from one accepted at its end. It also exercises the wait counter beyond its trivial single-cycle case. With a 32-bit operand, the set and clear merges can be checked on patterns that carry bits both inside and outside the old value.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  // Address width is fixed: access rights live at fixed bit positions.
  localparam int CSR_AW = 12;

  typedef enum logic [1:0] {
    OP_RSVD = 2'b00,
    OP_SWAP = 2'b01,
    OP_SET  = 2'b10,
    OP_CLR  = 2'b11
  } rmw_op_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_SUPER = 2'd1,
    LVL_RSVD  = 2'd2,
    LVL_MACH  = 2'd3
  } priv_lvl_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;

endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
  import csr_rmw_pkg::*;
(
  input  logic [CSR_AW-1:0] addr,
  input  logic [1:0]        op,
  input  logic              src_nz,
  input  logic [1:0]        priv,
  output logic              wants_write,
  output logic              illegal
);

  logic [1:0] min_lvl;
  logic       read_only;
  logic       op_rsvd;

  assign min_lvl   = addr[9:8];
  assign read_only = (addr[11:10] == 2'b11);
  assign op_rsvd   = (op == OP_RSVD);

  // R3: swap writes unconditionally; R4: set/clear only with a live source.
  always_comb begin
    unique case (op)
      OP_SWAP:        wants_write = 1'b1;
      OP_SET, OP_CLR: wants_write = src_nz;
      default:        wants_write = 1'b0;
    endcase
  end

  // R1 privilege, R2 read-only, R5 reserved code
  assign illegal = op_rsvd || (priv < min_lvl) || (read_only && wants_write);

endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge
  import csr_rmw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] src,
  input  logic [XLEN-1:0] old_val,
  output logic [XLEN-1:0] new_val
);

  always_comb begin
    unique case (op)
      OP_SWAP: new_val = src;
      OP_SET:  new_val = old_val | src;
      OP_CLR:  new_val = old_val & ~src;
      default: new_val = old_val;
    endcase
  end

endmodule

// File: rtl/csr_rmw_seq.sv
module csr_rmw_seq
  import csr_rmw_pkg::*;
#(
  parameter int RD_LAT = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic rd_strobe,
  output logic capture,
  output logic busy
);

  localparam int CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(RD_LAT - 1);

  seq_st_e          st;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rd_strobe <= 1'b0;
    end else begin
      rd_strobe <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st        <= ST_READ;
            rd_strobe <= 1'b1;
          end
        end
        ST_READ: begin
          st  <= ST_WAIT;
          cnt <= CNT_INIT;
        end
        ST_WAIT: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign capture = (st == ST_WAIT) && (cnt == '0);
  assign busy    = (st != ST_IDLE);

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int RD_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [11:0]       req_addr,
  input  logic [1:0]        req_op,
  input  logic [XLEN-1:0]   req_src,
  input  logic              req_src_nz,
  input  logic [1:0]        cur_priv,
  output logic              busy,
  output logic              csr_rd_en,
  output logic [11:0]       csr_addr,
  input  logic [XLEN-1:0]   csr_rd_data,
  output logic              csr_wr_en,
  output logic [XLEN-1:0]   csr_wr_data,
  output logic              rsp_valid,
  output logic              rsp_illegal,
  output logic [XLEN-1:0]   rsp_data
);

  logic            wants_write;
  logic            illegal;
  logic            accept;
  logic            accept_ok;
  logic            accept_bad;
  logic            capture;
  logic [1:0]      op_q;
  logic [XLEN-1:0] src_q;
  logic            wr_q;
  logic [XLEN-1:0] merged;

  csr_access_check u_check (
    .addr        (req_addr),
    .op          (req_op),
    .src_nz      (req_src_nz),
    .priv        (cur_priv),
    .wants_write (wants_write),
    .illegal     (illegal)
  );

  // R8: one operation in flight; requests during busy are dropped
  assign accept     = req_valid && !busy;
  assign accept_ok  = accept && !illegal;
  assign accept_bad = accept && illegal;

  csr_rmw_seq #(.RD_LAT(RD_LAT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept_ok),
    .rd_strobe (csr_rd_en),
    .capture   (capture),
    .busy      (busy)
  );

  csr_rmw_merge #(.XLEN(XLEN)) u_merge (
    .op      (op_q),
    .src     (src_q),
    .old_val (csr_rd_data),
    .new_val (merged)
  );

  // Request capture: held for the whole operation, shared by read and write.
  always_ff @(posedge clk) begin
    if (rst) begin
      csr_addr <= '0;
      op_q     <= OP_RSVD;
      src_q    <= '0;
      wr_q     <= 1'b0;
    end else if (accept_ok) begin
      csr_addr <= req_addr;
      op_q     <= req_op;
      src_q    <= req_src;
      wr_q     <= wants_write;
    end
  end

  // Registered response and write-back
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_data    <= '0;
      csr_wr_en   <= 1'b0;
      csr_wr_data <= '0;
    end else begin
      rsp_valid   <= accept_bad || capture;
      rsp_illegal <= accept_bad;
      csr_wr_en   <= capture && wr_q;
      if (capture) begin
        rsp_data    <= csr_rd_data;
        csr_wr_data <= merged;
      end else if (accept_bad) begin
        rsp_data    <= '0;
      end
    end
  end

endmodule

// File: rtl/csr_rmw_unit_chk.sv
module csr_rmw_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            csr_rd_en,
  input logic [11:0]     csr_addr,
  input logic [XLEN-1:0] csr_rd_data,
  input logic            csr_wr_en,
  input logic            rsp_valid,
  input logic            rsp_illegal,
  input logic [XLEN-1:0] rsp_data
);

  p_rdonly_no_write_r2: assert property (@(posedge clk) disable iff (rst)
    csr_wr_en |-> (csr_addr[11:10] != 2'b11));

  p_rd_single_r6: assert property (@(posedge clk) disable iff (rst)
    csr_rd_en |=> (!csr_rd_en && $stable(csr_addr)));

  p_write_in_rsp_r6: assert property (@(posedge clk) disable iff (rst)
    csr_wr_en |-> (rsp_valid && !rsp_illegal));

  p_old_value_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_illegal) |-> (rsp_data == $past(csr_rd_data)));

  p_illegal_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    rsp_illegal |-> (rsp_valid && !csr_rd_en && !csr_wr_en));

  p_read_while_busy_r8: assert property (@(posedge clk) disable iff (rst)
    csr_rd_en |-> busy);

  p_rsp_when_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_illegal) |-> !busy);

  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !csr_rd_en && !csr_wr_en && !rsp_valid && !rsp_illegal));

endmodule

bind csr_rmw_unit csr_rmw_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .csr_rd_en   (csr_rd_en),
  .csr_addr    (csr_addr),
  .csr_rd_data (csr_rd_data),
  .csr_wr_en   (csr_wr_en),
  .rsp_valid   (rsp_valid),
  .rsp_illegal (rsp_illegal),
  .rsp_data    (rsp_data)
);

// File: tb/test_csr_rmw_unit.sv
module test_csr_rmw_unit;

  localparam int XLEN   = 32;
  localparam int RD_LAT = 2;
  localparam int LEGAL_K = RD_LAT + 2;   // negedge index of a legal response

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            req_valid = 1'b0;
  logic [11:0]     req_addr = '0;
  logic [1:0]      req_op = '0;
  logic [31:0]     req_src = '0;
  logic            req_src_nz = 1'b0;
  logic [1:0]      cur_priv = '0;
  logic            busy, csr_rd_en, csr_wr_en, rsp_valid, rsp_illegal;
  logic [11:0]     csr_addr;
  logic [31:0]     csr_rd_data, csr_wr_data, rsp_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  csr_rmw_unit #(.XLEN(XLEN), .RD_LAT(RD_LAT)) i_csr_rmw_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_op(req_op), .req_src(req_src), .req_src_nz(req_src_nz),
    .cur_priv(cur_priv), .busy(busy), .csr_rd_en(csr_rd_en),
    .csr_addr(csr_addr), .csr_rd_data(csr_rd_data), .csr_wr_en(csr_wr_en),
    .csr_wr_data(csr_wr_data), .rsp_valid(rsp_valid),
    .rsp_illegal(rsp_illegal), .rsp_data(rsp_data)
  );

  // Register file model and independent shadow of its expected contents
  logic [31:0] mem    [4096];
  logic [31:0] shadow [4096];
  logic [31:0] rpipe  [RD_LAT];

  always @(posedge clk) begin
    if (csr_wr_en) mem[csr_addr] <= csr_wr_data;
    rpipe[0] <= csr_rd_en ? mem[csr_addr] : 32'hDEAD_BEEF;
    for (int i = 1; i < RD_LAT; i++) rpipe[i] <= rpipe[i-1];
  end
  assign csr_rd_data = rpipe[RD_LAT-1];

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [11:0] a, input logic [1:0] op,
                       input logic [31:0] s, input logic nz, input logic [1:0] pv);
    req_valid = v; req_addr = a; req_op = op; req_src = s;
    req_src_nz = nz; cur_priv = pv;
  endtask

  // One request, observed over its whole window; expectations from R1..R7
  task automatic run_op(input logic [11:0] a, input logic [1:0] op,
                        input logic [31:0] s, input logic nz,
                        input logic [1:0] pv, input logic ill, input string tag);
    logic [31:0] old_v, new_v, got_d, got_w, got_wa;
    logic        wr_exp, got_ill;
    int          rsp_k, rsp_n, rd_n, wr_n;
    old_v  = shadow[a];
    wr_exp = !ill && ((op == 2'b01) || nz);
    new_v  = (op == 2'b01) ? s : (op == 2'b10) ? (old_v | s) : (old_v & ~s);
    rsp_k = -1; rsp_n = 0; rd_n = 0; wr_n = 0;
    got_d = '0; got_w = '0; got_wa = '0; got_ill = 1'b0;
    @(negedge clk);
    drive(1'b1, a, op, s, nz, pv);
    for (int k = 1; k <= RD_LAT + 4; k++) begin
      @(negedge clk);
      if (k == 1) req_valid = 1'b0;
      if (rsp_valid) begin
        rsp_n++;
        if (rsp_k < 0) begin rsp_k = k; got_d = rsp_data; got_ill = rsp_illegal; end
      end
      if (csr_rd_en) rd_n++;
      if (csr_wr_en) begin wr_n++; got_w = csr_wr_data; got_wa = 32'(csr_addr); end
    end
    chk(tag, "illegal flag", 32'(got_ill), 32'(ill));
    chk(tag, "response cycle", 32'(rsp_k), ill ? 32'd1 : 32'(LEGAL_K));
    chk(tag, "response count", 32'(rsp_n), 32'd1);
    chk(tag, "read strobes", 32'(rd_n), ill ? 32'd0 : 32'd1);
    chk(tag, "write strobes", 32'(wr_n), 32'(wr_exp));
    if (!ill) chk(tag, "old value", got_d, old_v);
    if (wr_exp) begin
      chk(tag, "write data", got_w, new_v);
      chk(tag, "write addr", got_wa, 32'(a));
      shadow[a] = new_v;
    end
  endtask

  typedef struct packed {
    logic [3:0]  rq;
    logic [11:0] addr;
    logic [1:0]  op;
    logic [31:0] src;
    logic        nz;
    logic [1:0]  pv;
    logic        ill;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{4'd3, 12'h300, 2'b01, 32'h1234_5678, 1'b1, 2'd3, 1'b0}, // R3 swap
    '{4'd5, 12'h300, 2'b10, 32'h0000_F0F0, 1'b1, 2'd3, 1'b0}, // R5 set
    '{4'd5, 12'h300, 2'b11, 32'h1030_0030, 1'b1, 2'd3, 1'b0}, // R5 clear
    '{4'd4, 12'h300, 2'b10, 32'hFFFF_FFFF, 1'b0, 2'd3, 1'b0}, // R4 set as read
    '{4'd1, 12'h100, 2'b01, 32'hAAAA_0001, 1'b1, 2'd0, 1'b1}, // R1 user on super reg
    '{4'd1, 12'h100, 2'b01, 32'hAAAA_0002, 1'b1, 2'd1, 1'b0}, // R1 super on super reg
    '{4'd1, 12'h300, 2'b10, 32'h0000_0001, 1'b1, 2'd1, 1'b1}, // R1 super on machine reg
    '{4'd2, 12'hC00, 2'b10, 32'h0000_0000, 1'b0, 2'd0, 1'b0}, // R2 read of read-only
    '{4'd2, 12'hC00, 2'b10, 32'h0000_0004, 1'b1, 2'd0, 1'b1}, // R2 set on read-only
    '{4'd3, 12'hF11, 2'b01, 32'h0000_0000, 1'b0, 2'd3, 1'b1}, // R3 swap nz=0 read-only
    '{4'd4, 12'h040, 2'b11, 32'hFFFF_FFFF, 1'b0, 2'd0, 1'b0}, // R4 clear as read
    '{4'd3, 12'h040, 2'b01, 32'h0000_0000, 1'b0, 2'd0, 1'b0}, // R3 swap nz=0 writes
    '{4'd5, 12'h340, 2'b00, 32'h5555_5555, 1'b1, 2'd3, 1'b1}, // R5 reserved code
    '{4'd1, 12'h200, 2'b01, 32'hBEEF_0200, 1'b1, 2'd3, 1'b0}, // R1 level 2 from machine
    '{4'd1, 12'h200, 2'b01, 32'hBEEF_0201, 1'b1, 2'd1, 1'b1}  // R1 level 2 from super
  };

  initial begin
    for (int a = 0; a < 4096; a++) begin
      mem[a]    = 32'hA5C3_0000 ^ (a * 32'h0001_0101);
      shadow[a] = 32'hA5C3_0000 ^ (a * 32'h0001_0101);
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk("R9", "busy", 32'(busy), 32'd0);
    chk("R9", "rd strobe", 32'(csr_rd_en), 32'd0);
    chk("R9", "wr strobe", 32'(csr_wr_en), 32'd0);
    chk("R9", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R9", "rsp_illegal", 32'(rsp_illegal), 32'd0);

    for (int i = 0; i < NV; i++)
      run_op(VECS[i].addr, VECS[i].op, VECS[i].src, VECS[i].nz, VECS[i].pv,
             VECS[i].ill, $sformatf("R%0d", VECS[i].rq));

    // R8: request during busy is dropped
    begin
      int rd_n, rsp_n;
      rd_n = 0; rsp_n = 0;
      @(negedge clk);
      drive(1'b1, 12'h341, 2'b01, 32'h1111_1111, 1'b1, 2'd3);
      for (int k = 1; k <= RD_LAT + 5; k++) begin
        @(negedge clk);
        if (k == 1) begin
          chk("R8", "busy after accept", 32'(busy), 32'd1);
          drive(1'b1, 12'h342, 2'b01, 32'h2222_2222, 1'b1, 2'd3);
        end else req_valid = 1'b0;
        if (csr_rd_en) rd_n++;
        if (rsp_valid) rsp_n++;
      end
      chk("R8", "reads with dropped request", 32'(rd_n), 32'd1);
      chk("R8", "responses with dropped request", 32'(rsp_n), 32'd1);
      shadow[12'h341] = 32'h1111_1111;
      run_op(12'h342, 2'b10, 32'h0, 1'b0, 2'd3, 1'b0, "R8");
      run_op(12'h341, 2'b10, 32'h0, 1'b0, 2'd3, 1'b0, "R8");
    end

    // R8/R6: request in the response cycle sees the value just written
    @(negedge clk);
    drive(1'b1, 12'h343, 2'b01, 32'hC0DE_0343, 1'b1, 2'd3);
    @(negedge clk); req_valid = 1'b0;
    repeat (LEGAL_K - 1) @(negedge clk);
    chk("R8", "response cycle busy", 32'(busy), 32'd0);
    chk("R6", "response valid", 32'(rsp_valid), 32'd1);
    drive(1'b1, 12'h343, 2'b10, 32'hFFFF_FFFF, 1'b0, 2'd3);
    @(negedge clk); req_valid = 1'b0;
    repeat (LEGAL_K - 1) @(negedge clk);
    chk("R8", "follow-on response", 32'(rsp_valid && !rsp_illegal), 32'd1);
    chk("R8", "follow-on reads new value", rsp_data, 32'hC0DE_0343);
    shadow[12'h343] = 32'hC0DE_0343;
    repeat (3) @(negedge clk);

    // R7: back-to-back illegal requests, one response each
    drive(1'b1, 12'h300, 2'b01, 32'h0, 1'b1, 2'd0);
    @(negedge clk);
    chk("R7", "first illegal rsp", 32'({rsp_valid, rsp_illegal}), 32'd3);
    drive(1'b1, 12'hC01, 2'b11, 32'h1, 1'b1, 2'd3);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "second illegal rsp", 32'({rsp_valid, rsp_illegal}), 32'd3);
    chk("R7", "no read strobe", 32'(csr_rd_en), 32'd0);
    @(negedge clk);
    chk("R7", "single-cycle flag", 32'(rsp_valid), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule